// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial flash command per trigger. Software sets up an opcode, a transmit length and a receive length, places the outgoing bytes in a byte-wide buffer window, and then writes the trigger. The engine pulls chip select low and sends the opcode from its own register. It then sends the transmit bytes from the buffer and clocks in the receive bytes. Each received byte is stored in the same buffer, directly behind the bytes that were sent. Software polls a status word for the busy flag and then reads the answers out of the window.

The serial side is single-bit SPI mode 0 only. SCK idles low. MOSI changes after the falling edge, and MISO is sampled on the rising edge. The most significant bit goes first. SCK runs at the system clock divided by `CLK_DIV`. The status word shows how many bytes have completed and where the buffer read and write pointers stand, so progress can be followed during a transfer.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low, and every mapped register and status byte reads 0.
- R2: A write with bit 7 set to offset 0x47, made while idle, starts a command. Offset 0x47 always reads 0.
- R3: While selected, SCK has period `CLK_DIV` clocks and goes high `CLK_DIV/2` clocks after each bit starts. The opcode (offset 0x45) is sent first, then buffer bytes 0 to TX-1, MSB first. TX is set at offset 0x48.
- R4: After the transmit bytes, RX bytes are clocked in with MOSI held low. RX is set at offset 0x4B. Received byte j is stored at buffer index TX+j.
- R5: Chip select stays low for the whole command. It rises `CLK_DIV` clocks after the last falling SCK edge. MOSI is low while deselected.
- R6: Status at 0x4C..0x4F is a little-endian 32-bit word. Bit 31 is busy. Bits 7:0 hold the done byte count, bits 14:8 the write pointer and bits 22:16 the read pointer. After a command: done = 1+TX+RX, read pointer = TX, write pointer = RX.
- R7: At the start of each command, the done count and both pointers return to 0.
- R8: A trigger is ignored when TX+RX exceeds the buffer depth (71). A command with TX+RX equal to the depth runs.
- R9: All bus writes made while busy are ignored: trigger, opcode, counts and buffer.
- R10: The buffer is mapped byte by byte from offset 0x80 and is readable and writable while idle. Unmapped offsets, including 0x80+depth, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 8 | Byte offset for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The assertions take for granted that the bus never writes the length registers while a command is running. They also expect the trigger to come as a single strobed write while idle. The stimulus keeps to one write per pair of cycles, each applied on the falling clock edge. The only writes issued during a transfer are the deliberate ones that R9 says must be discarded. MISO is driven only in reaction to the engine's own SCK phase. A bus-level model predicts the expected values from the requirements alone.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [7:0] OFS_OPC  = 8'h45;
  localparam logic [7:0] OFS_TRIG = 8'h47;
  localparam logic [7:0] OFS_TXN  = 8'h48;
  localparam logic [7:0] OFS_RXN  = 8'h4B;
  localparam logic [7:0] OFS_STAT = 8'h4C;
  localparam logic [7:0] OFS_FIFO = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_state_e;
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int DEPTH = 71,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (int'(raddr_a_i) < DEPTH) ? mem_q[raddr_a_i] : 8'h00;
  assign rdata_b_o = (int'(raddr_b_i) < DEPTH) ? mem_q[raddr_b_i] : 8'h00;
endmodule

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int HALF = 2,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i || wrap)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH   = 71,
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       spi_cs_no,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int AW   = $clog2(DEPTH);

  eng_state_e state_q;
  logic [7:0] opc_q, txn_q, rxn_q, sh_q, rx_q, byte_q, done_q;
  logic [6:0] rd_ptr_q, wr_ptr_q;
  logic [2:0] bit_q;
  logic       cs_n_q, sck_q, tail_q;

  logic        busy, tick, bus_wr, start, fifo_hit, eng_we, byte_end;
  logic [7:0]  fifo_off, fifo_rd_bus, fifo_rd_eng;
  logic [8:0]  sum;
  logic [31:0] status;

  assign busy     = (state_q != ST_IDLE);
  assign bus_wr   = wr_en_i && !busy;
  assign fifo_off = addr_i - OFS_FIFO;
  assign fifo_hit = addr_i[7] && (fifo_off < 8'(DEPTH));
  assign sum      = {1'b0, txn_q} + {1'b0, rxn_q};
  assign start    = bus_wr && (addr_i == OFS_TRIG) && wdata_i[7] && (sum <= 9'(DEPTH));
  assign byte_end = (state_q == ST_SHIFT) && tick && sck_q && (bit_q == 3'd7);
  assign eng_we   = byte_end && (byte_q > txn_q);

  spi_eng_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy),
    .tick_o(tick)
  );

  spi_eng_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     ((bus_wr && fifo_hit) || eng_we),
    .waddr_i  (eng_we ? AW'(txn_q + {1'b0, wr_ptr_q}) : AW'(fifo_off)),
    .wdata_i  (eng_we ? rx_q : wdata_i),
    .raddr_a_i(AW'(fifo_off)),
    .rdata_a_o(fifo_rd_bus),
    .raddr_b_i(AW'(rd_ptr_q)),
    .rdata_b_o(fifo_rd_eng)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      txn_q <= '0;
      rxn_q <= '0;
    end else if (bus_wr) begin
      if (addr_i == OFS_OPC) opc_q <= wdata_i;
      if (addr_i == OFS_TXN) txn_q <= wdata_i;
      if (addr_i == OFS_RXN) rxn_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      sck_q    <= 1'b0;
      tail_q   <= 1'b0;
      sh_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      done_q   <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_SHIFT;
          cs_n_q   <= 1'b0;
          sck_q    <= 1'b0;
          tail_q   <= 1'b0;
          sh_q     <= opc_q;
          bit_q    <= '0;
          byte_q   <= '0;
          done_q   <= '0;
          rd_ptr_q <= '0;
          wr_ptr_q <= '0;
        end
        ST_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], spi_miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              bit_q  <= '0;
              done_q <= done_q + 8'd1;
              if (eng_we) wr_ptr_q <= wr_ptr_q + 7'd1;
              if (byte_q == sum[7:0]) begin
                state_q <= ST_TAIL;
                sh_q    <= '0;
              end else begin
                byte_q <= byte_q + 8'd1;
                if (byte_q < txn_q) begin
                  sh_q     <= fifo_rd_eng;
                  rd_ptr_q <= rd_ptr_q + 7'd1;
                end else begin
                  sh_q <= '0;
                end
              end
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_TAIL: if (tick) begin
          // hold select through one idle SCK period
          if (!tail_q) begin
            tail_q <= 1'b1;
          end else begin
            tail_q  <= 1'b0;
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign status     = {busy, 8'h00, rd_ptr_q, 1'b0, wr_ptr_q, done_q};
  assign spi_cs_no  = cs_n_q;
  assign spi_sck_o  = sck_q;
  assign spi_mosi_o = sh_q[7];

  always_comb begin
    case (addr_i)
      OFS_OPC:          rdata_o = opc_q;
      OFS_TXN:          rdata_o = txn_q;
      OFS_RXN:          rdata_o = rxn_q;
      OFS_STAT:         rdata_o = status[7:0];
      OFS_STAT + 8'd1:  rdata_o = status[15:8];
      OFS_STAT + 8'd2:  rdata_o = status[23:16];
      OFS_STAT + 8'd3:  rdata_o = status[31:24];
      default:          rdata_o = fifo_hit ? fifo_rd_bus : 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_flash_cmd_engine_chk.sv
module spi_flash_cmd_engine_chk #(
  parameter int DEPTH = 71
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] addr_i,
  input logic       trig_bit_i,
  input logic       cs_n_i,
  input logic       sck_i,
  input logic       mosi_i,
  input logic       busy_i,
  input logic [6:0] rd_ptr_i,
  input logic [6:0] wr_ptr_i,
  input logic [7:0] done_i,
  input logic [7:0] txn_i,
  input logic [7:0] rxn_i
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sck_i); // R3

  AST_MOSI_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !mosi_i); // R5

  AST_BUSY_TRACKS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i == !cs_n_i); // R6

  AST_DONE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i <= 8'(DEPTH + 1)); // R6

  AST_START_FROM_TRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> $past(wr_en_i && (addr_i == 8'h47) && trig_bit_i)); // R2

  AST_START_CLEARS_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> (rd_ptr_i == 7'd0) && (wr_ptr_i == 7'd0) && (done_i == 8'd0)); // R7

  AST_START_FITS_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> (({1'b0, txn_i} + {1'b0, rxn_i}) <= 9'(DEPTH))); // R8

  AST_LENGTHS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && $past(!cs_n_i)) |-> ($stable(txn_i) && $stable(rxn_i))); // R9
endmodule

bind spi_flash_cmd_engine spi_flash_cmd_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .trig_bit_i(wdata_i[7]),
  .cs_n_i    (spi_cs_no),
  .sck_i     (spi_sck_o),
  .mosi_i    (spi_mosi_o),
  .busy_i    (status[31]),
  .rd_ptr_i  (rd_ptr_q),
  .wr_ptr_i  (wr_ptr_q),
  .done_i    (done_q),
  .txn_i     (txn_q),
  .rxn_i     (rxn_q)
);

// File: tb/spi_flash_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_test;
  localparam int DEPTH = 71;
  localparam int H     = 2;

  logic       clk = 0, rst_n = 0, wr_en = 0, miso = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic       cs_n, sck, mosi;
  int n_chk = 0, n_fail = 0;

  spi_flash_cmd_engine #(.DEPTH(DEPTH), .CLK_DIV(2*H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] m_opc = 0, m_txn = 0, m_rxn = 0, m_seed = 0;
  logic [7:0] m_fifo [DEPTH];
  bit m_active = 0;
  int k = 0, nb = 0;

  function automatic logic [7:0] rxpat(input int j);
    return 8'hC3 ^ 8'(j * 29) ^ m_seed;
  endfunction

  function automatic logic [7:0] tx_byte(input int b);
    if (b == 0) return m_opc;
    if (b <= int'(m_txn)) return m_fifo[b-1];
    return 8'h00;
  endfunction

  initial for (int i = 0; i < DEPTH; i++) m_fifo[i] = 0;

  always @(posedge clk) begin
    int b;
    bit e_cs, e_sck, e_mosi;
    #2;
    if (rst_n) begin
      if (m_active) k++;
      else if (wr_en && addr == 8'h47 && wdata[7] && (int'(m_txn) + int'(m_rxn) <= DEPTH)) begin
        m_active = 1; k = 0; nb = 1 + int'(m_txn) + int'(m_rxn);
      end else if (wr_en) begin
        if (addr == 8'h45) m_opc = wdata;
        if (addr == 8'h48) m_txn = wdata;
        if (addr == 8'h4B) m_rxn = wdata;
        if (addr >= 8'h80 && int'(addr) < 128 + DEPTH) m_fifo[int'(addr) - 128] = wdata;
      end
      if (m_active && k >= nb * 16 * H + 2 * H) begin
        m_active = 0;
        for (int j = 0; j < int'(m_rxn); j++) m_fifo[int'(m_txn) + j] = rxpat(j);
      end
    end
    e_cs = !m_active; e_sck = 0; e_mosi = 0; b = 0;
    if (m_active && k < nb * 16 * H) begin
      b = k / (2 * H);
      e_sck = ((k / H) % 2) == 1;
      e_mosi = tx_byte(b / 8)[7 - (b % 8)];
    end
    check(cs_n == e_cs, "R5", cs_n, e_cs);
    check(sck == e_sck, "R3", sck, e_sck);
    check(mosi == e_mosi, "R3/R4", mosi, e_mosi);
    if (m_active && k < nb * 16 * H && (b / 8) > int'(m_txn))
      miso = rxpat(b / 8 - int'(m_txn) - 1)[7 - (b % 8)];
    else
      miso = 1'b1;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd_stat(output logic [31:0] s);
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin rd(8'h4C + 8'(i), v); s[i*8 +: 8] = v; end
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 5000; i++) begin rd(8'h4F, v); if (!v[7]) break; end
  endtask

  task automatic final_report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic post_check(input int tx, input int rx);
    logic [31:0] s;
    logic [7:0] v;
    rd_stat(s);
    check(s[31] == 0, "R6", s[31], 0);
    check(s[7:0] == 8'(1 + tx + rx), "R6", s[7:0], 1 + tx + rx);
    check(s[22:16] == 7'(tx), "R6", s[22:16], tx);
    check(s[14:8] == 7'(rx), "R6", s[14:8], rx);
    for (int j = 0; j < rx; j++) begin
      rd(8'h80 + 8'(tx + j), v);
      check(v == rxpat(j), "R4", v, rxpat(j));
    end
  endtask

  task automatic setup(input logic [7:0] op, input int tx, input int rx, input logic [7:0] seed);
    m_seed = seed;
    wr(8'h45, op); wr(8'h48, 8'(tx)); wr(8'h4B, 8'(rx));
    for (int i = 0; i < tx; i++) wr(8'h80 + 8'(i), 8'h10 + 8'(i * 7));
  endtask

  initial begin
    logic [31:0] s;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd_stat(s); check(s == 0, "R1", s, 0);
    rd(8'h45, v); check(v == 0, "R1", v, 0);
    rd(8'h48, v); check(v == 0, "R1", v, 0);
    rd(8'h4B, v); check(v == 0, "R1", v, 0);

    // read-id style: opcode then receive only
    setup(8'h9F, 0, 3, 8'h11);
    wr(8'h47, 8'h80);
    rd(8'h47, v); check(v == 0, "R2", v, 0);
    rd_stat(s); check(s[31] == 1, "R2", s[31], 1);
    wait_idle(); post_check(0, 3);

    // read with address bytes; progress restarts (R7), busy writes dropped (R9)
    setup(8'h03, 3, 4, 8'h5A);
    rd(8'h81, v); check(v == 8'h17, "R10", v, 8'h17);
    wr(8'h47, 8'h80);
    rd_stat(s);
    check(s[7:0] == 0, "R7", s[7:0], 0);
    check(s[14:8] == 0, "R7", s[14:8], 0);
    check(s[22:16] == 0, "R7", s[22:16], 0);
    wr(8'h80, 8'hEE); wr(8'h45, 8'hFF); wr(8'h48, 8'h05); wr(8'h47, 8'h80);
    wait_idle(); post_check(3, 4);
    rd(8'h80, v); check(v == 8'h10, "R9", v, 8'h10);
    rd(8'h45, v); check(v == 8'h03, "R9", v, 8'h03);
    rd(8'h48, v); check(v == 8'h03, "R9", v, 8'h03);

    // opcode only
    setup(8'h06, 0, 0, 8'h00);
    wr(8'h47, 8'h80); wait_idle(); post_check(0, 0);

    // trigger without bit 7 does nothing
    wr(8'h47, 8'h7F);
    rd_stat(s); check(s[31] == 0, "R2", s[31], 0);

    // exactly full buffer (R8 boundary)
    setup(8'h0B, 2, 69, 8'hA7);
    wr(8'h47, 8'h80); wait_idle(); post_check(2, 69);

    // oversized request rejected
    wr(8'h48, 8'd40); wr(8'h4B, 8'd32);
    wr(8'h47, 8'h80);
    rd_stat(s); check(s[31] == 0, "R8", s[31], 0);
    check(s[7:0] == 8'd72, "R8", s[7:0], 72);

    // window edges
    rd(8'h80 + 8'(DEPTH), v); check(v == 0, "R10", v, 0);
    rd(8'h50, v); check(v == 0, "R10", v, 0);
    repeat (10) @(negedge clk);
    final_report();
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    final_report();
  end
endmodule